// File: doc/BRIEF.md
# Dual-Channel Down-Counting Interval Timer

This block is a programmable interval timer on an APB slave port. Each channel holds a 4-bit control word, a 32-bit reload value and a 32-bit counter. The counter counts down and reloads itself on underflow. Each underflow sets a sticky per-channel status flag. A single interrupt line combines all status flags, each gated by its own enable bit.

Each channel picks its count source. It either counts on every APB clock cycle, or it counts once per rising edge of an asynchronous tick input. That tick input is synchronised inside the block. Software typically runs one channel free with an all-ones reload and reads the inverted counter as a rising timestamp. It uses the other channel to raise periodic or one-off interrupts.

Per-channel bits in the enable, interrupt-enable and status registers sit at bit position 4·c. The other bits of each nibble are reserved and read zero.

Top module: `dual_interval_timer`

## Requirements
- R1: Out of reset every register reads zero except the identity word (offset 0x00, reads ID_VALUE) and the configuration word (offset 0x10, reads the channel count NCH). Unmapped offsets read zero, `pready` is always 1, `pslverr` is always 0 and `irq` is 0.
- R2: Channel c has its control word at 0x20+16·c (bits [3:0] stored, upper bits read zero), its reload word at 0x24+16·c (32 bits) and its counter at 0x28+16·c. The interrupt enable (0x14) and channel enable (0x1C) registers hold channel c in bit 4·c, and the other bits read zero.
- R3: Writing a 1 to a channel's enable bit while that bit is 0 loads the counter from the reload word. Writing a 1 while the bit is already 1 leaves the count running undisturbed.
- R4: With the channel enabled, control bits [2:0] = 1 (32-bit mode) and control bit 3 = 1 (APB clock source), the counter drops by one on every clock.
- R5: A tick that finds the counter at zero loads the reload value and sets the channel's status bit. The period is therefore reload+1 ticks.
- R6: A write to the counter register sets the counter to the written value, and this write takes priority over a tick in the same cycle.
- R7: Clearing the channel enable bit freezes the counter at its current value.
- R8: Mode values other than 1 (including 2 and 3) leave the counter frozen even while the channel is enabled.
- R9: With control bit 3 = 0, the counter steps once per rising edge of `ext_tick`, after a two-flop synchroniser. A high level that is held does not produce further steps.
- R10: Status bits at 0x18 (channel c in bit 4·c) stay set until software writes a 1 to that bit. Writing 1 to any other bit leaves them unchanged.
- R11: `irq` is high exactly when some channel has both its status bit and its interrupt enable bit set.
- R12: A reload of 0xFFFFFFFF gives a free-running down-count, so the inverted counter value rises by one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock, also the internal count clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| ext_tick | input | 1 | Asynchronous external count tick |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: NCH = 2, AW = 8 and the default identity word. With two channels, the nibble packing can be seen at bit 4 as well as bit 0, and the interrupt gating can be checked across channels. With the 8-bit address, the second channel's window and the unmapped holes below 0x20 and above 0x3F fall within reach. Channel 0 is checked on the clock source with exact cycle-counted values. Channel 1 is checked on the external tick, whose edges the bench places itself, so underflow, reload and the status flag show up at known counts.

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int          NCH      = 2,
  parameter int          AW       = 8,
  parameter logic [31:0] ID_VALUE = 32'h5049_0102
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic          ext_tick,
  output logic          irq
);

  localparam logic [AW-1:0] A_ID   = AW'(8'h00);
  localparam logic [AW-1:0] A_CFG  = AW'(8'h10);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h14);
  localparam logic [AW-1:0] A_STA  = AW'(8'h18);
  localparam logic [AW-1:0] A_CHEN = AW'(8'h1C);
  localparam int            CH_BASE   = 32;
  localparam int            CH_STRIDE = 16;
  localparam logic [2:0]    MODE_32   = 3'd1;

  logic                   apb_wr;
  logic [2:0]             ext_sync;
  logic                   ext_rise;
  logic [NCH-1:0]         en_q, ien_q, sta_q, tick;
  logic [NCH-1:0][3:0]    ctl_q;
  logic [NCH-1:0][31:0]   rld_q, cnt_q;

  assign apb_wr   = psel & penable & pwrite;
  assign pready   = 1'b1;
  assign pslverr  = 1'b0;
  assign ext_rise = ext_sync[1] & ~ext_sync[2];
  assign irq      = |(sta_q & ien_q);

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) ext_sync <= '0;
    else          ext_sync <= {ext_sync[1:0], ext_tick};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] A_CTL = AW'(CH_BASE + CH_STRIDE * c);
    localparam logic [AW-1:0] A_RLD = AW'(CH_BASE + CH_STRIDE * c + 4);
    localparam logic [AW-1:0] A_CNT = AW'(CH_BASE + CH_STRIDE * c + 8);

    logic wr_cnt, en_rise, run, wrap;

    assign tick[c] = ctl_q[c][3] | ext_rise;
    assign wr_cnt  = apb_wr && paddr == A_CNT;
    assign en_rise = apb_wr && paddr == A_CHEN && pwdata[4*c] && !en_q[c];
    assign run     = en_q[c] && tick[c] && ctl_q[c][2:0] == MODE_32 && !wr_cnt;
    assign wrap    = run && cnt_q[c] == '0;

    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        ctl_q[c] <= '0;
        rld_q[c] <= '0;
        cnt_q[c] <= '0;
        en_q[c]  <= 1'b0;
        ien_q[c] <= 1'b0;
        sta_q[c] <= 1'b0;
      end else begin
        if (apb_wr && paddr == A_CTL)  ctl_q[c] <= pwdata[3:0];
        if (apb_wr && paddr == A_RLD)  rld_q[c] <= pwdata;
        if (apb_wr && paddr == A_CHEN) en_q[c]  <= pwdata[4*c];
        if (apb_wr && paddr == A_IEN)  ien_q[c] <= pwdata[4*c];

        if (wr_cnt)       cnt_q[c] <= pwdata;
        else if (en_rise) cnt_q[c] <= rld_q[c];
        else if (wrap)    cnt_q[c] <= rld_q[c];
        else if (run)     cnt_q[c] <= cnt_q[c] - 32'd1;

        if (wrap)                                          sta_q[c] <= 1'b1;
        else if (apb_wr && paddr == A_STA && pwdata[4*c])  sta_q[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr == A_ID)  prdata = ID_VALUE;
    if (paddr == A_CFG) prdata = 32'(NCH);
    for (int c = 0; c < NCH; c++) begin
      if (paddr == A_IEN)  prdata[4*c] = ien_q[c];
      if (paddr == A_STA)  prdata[4*c] = sta_q[c];
      if (paddr == A_CHEN) prdata[4*c] = en_q[c];
      if (paddr == AW'(CH_BASE + CH_STRIDE * c))     prdata = {28'd0, ctl_q[c]};
      if (paddr == AW'(CH_BASE + CH_STRIDE * c + 4)) prdata = rld_q[c];
      if (paddr == AW'(CH_BASE + CH_STRIDE * c + 8)) prdata = cnt_q[c];
    end
  end

endmodule

// File: rtl/dual_interval_timer_sva.sv
module dual_interval_timer_sva #(
  parameter int NCH = 2
) (
  input logic                 pclk,
  input logic                 presetn,
  input logic                 psel,
  input logic                 penable,
  input logic                 pwrite,
  input logic                 pready,
  input logic                 pslverr,
  input logic [NCH-1:0]       en_q,
  input logic [NCH-1:0]       tick,
  input logic [NCH-1:0]       sta_q,
  input logic [NCH-1:0][3:0]  ctl_q,
  input logic [NCH-1:0][31:0] rld_q,
  input logic [NCH-1:0][31:0] cnt_q
);

  logic apb_wr;
  assign apb_wr = psel & penable & pwrite;

  assert_ready_R1: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_step_R4: assert property (@(posedge pclk) disable iff (!presetn)
      (en_q[c] && tick[c] && ctl_q[c][2:0] == 3'd1 && cnt_q[c] != 32'd0 && !apb_wr)
      |=> cnt_q[c] == $past(cnt_q[c]) - 32'd1);

    assert_wrap_R5: assert property (@(posedge pclk) disable iff (!presetn)
      (en_q[c] && tick[c] && ctl_q[c][2:0] == 3'd1 && cnt_q[c] == 32'd0 && !apb_wr)
      |=> (cnt_q[c] == $past(rld_q[c]) && sta_q[c]));

    assert_freeze_R7: assert property (@(posedge pclk) disable iff (!presetn)
      (!en_q[c] && !apb_wr) |=> $stable(cnt_q[c]));

    assert_mode_hold_R8: assert property (@(posedge pclk) disable iff (!presetn)
      (ctl_q[c][2:0] != 3'd1 && !apb_wr) |=> $stable(cnt_q[c]));

    assert_sticky_R10: assert property (@(posedge pclk) disable iff (!presetn)
      (sta_q[c] && !apb_wr) |=> sta_q[c]);
  end

endmodule

bind dual_interval_timer dual_interval_timer_sva #(.NCH(NCH)) sva_i (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .pready(pready), .pslverr(pslverr), .en_q(en_q),
  .tick(tick), .sta_q(sta_q), .ctl_q(ctl_q), .rld_q(rld_q), .cnt_q(cnt_q)
);

// File: tb/dual_interval_timer_tb_top.sv
module dual_interval_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_EXP = 32'h5049_0102;

  logic pclk = 1'b0, presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0, ext_tick = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {logic [31:0] exp; bit chk; string tag;} item_t;
  item_t exp_q[$];
  item_t cur;
  logic [31:0] last_rd;

  dual_interval_timer #(.NCH(2), .AW(8), .ID_VALUE(ID_EXP)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .ext_tick(ext_tick), .irq(irq)
  );

  always #(CLK_PERIOD/2) pclk = ~pclk;

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge pclk) begin
    #(CLK_PERIOD/4);
    if (psel && penable && !pwrite && exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      last_rd = prdata;
      if (cur.chk) check32(cur.tag, prdata, cur.exp);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, bit c, string tag);
    item_t it;
    it.exp = e; it.chk = c; it.tag = tag;
    exp_q.push_back(it);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic rd_exp(logic [7:0] a, logic [31:0] e, string tag);
    rd(a, e, 1'b1, tag);
  endtask

  task automatic check_irq(logic e, string tag);
    #(CLK_PERIOD/4);
    check32(tag, {31'd0, irq}, {31'd0, e});
  endtask

  task automatic pulse();
    @(negedge pclk); ext_tick = 1;
    repeat (3) @(negedge pclk);
    ext_tick = 0;
    repeat (5) @(negedge pclk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    #(CLK_PERIOD/4);
    check32("R1 pready", {31'd0, pready}, 32'd1);
    check32("R1 pslverr", {31'd0, pslverr}, 32'd0);
    check32("R1 irq", {31'd0, irq}, 32'd0);
    rd_exp(8'h00, ID_EXP, "R1 id");
    rd_exp(8'h10, 32'd2, "R1 cfg");
    rd_exp(8'h0C, 32'd0, "R1 hole");
    rd_exp(8'h80, 32'd0, "R1 hole high");
    rd_exp(8'h1C, 32'd0, "R1 chen");
    rd_exp(8'h18, 32'd0, "R1 status");
    rd_exp(8'h28, 32'd0, "R1 count");

    wr(8'h20, 32'hFFFF_FFFF); rd_exp(8'h20, 32'h0000_000F, "R2 ctl0");
    wr(8'h24, 32'h1234_5678); rd_exp(8'h24, 32'h1234_5678, "R2 rld0");
    wr(8'h30, 32'h0000_0009); rd_exp(8'h30, 32'h0000_0009, "R2 ctl1");
    wr(8'h14, 32'hFFFF_FFFF); rd_exp(8'h14, 32'h0000_0011, "R2 ien");
    wr(8'h14, 32'h0);

    wr(8'h28, 32'd100); rd_exp(8'h28, 32'd100, "R6 preload idle");

    wr(8'h20, 32'hA); wr(8'h24, 32'd20); wr(8'h1C, 32'h1);
    rd_exp(8'h28, 32'd20, "R3 enable loads");
    rd_exp(8'h28, 32'd20, "R8 mode 2 holds");
    wr(8'h1C, 32'h0);

    wr(8'h20, 32'h9); wr(8'h24, 32'hFFFF_FFFF); wr(8'h1C, 32'h1);
    rd_exp(8'h28, 32'hFFFF_FFFD, "R4 step per clock");
    rd_exp(8'h28, 32'hFFFF_FFFA, "R12 free run");
    wr(8'h1C, 32'h1);
    rd_exp(8'h28, 32'hFFFF_FFF4, "R3 no reload when set");

    wr(8'h28, 32'd50); rd_exp(8'h28, 32'd48, "R6 preload running");

    wr(8'h1C, 32'h0);
    rd(8'h28, 32'd0, 1'b0, "");
    repeat (4) @(negedge pclk);
    rd_exp(8'h28, last_rd, "R7 freeze");

    wr(8'h18, 32'hFF); wr(8'h14, 32'h1); wr(8'h24, 32'd3); wr(8'h1C, 32'h1);
    repeat (3) @(negedge pclk);
    check_irq(1'b0, "R5 before wrap");
    @(negedge pclk);
    check_irq(1'b1, "R5 wrap after reload+1");
    wr(8'h1C, 32'h0);
    rd_exp(8'h18, 32'h1, "R10 status set");
    wr(8'h18, 32'h1);
    rd_exp(8'h18, 32'h0, "R10 cleared");
    check_irq(1'b0, "R11 cleared");

    wr(8'h30, 32'h1); wr(8'h34, 32'd2); wr(8'h1C, 32'h10);
    rd_exp(8'h38, 32'd2, "R9 loaded");
    repeat (10) @(negedge pclk);
    rd_exp(8'h38, 32'd2, "R9 no edge no step");
    pulse(); rd_exp(8'h38, 32'd1, "R9 one edge");
    pulse(); rd_exp(8'h38, 32'd0, "R9 second edge");
    check_irq(1'b0, "R11 none");
    pulse(); rd_exp(8'h38, 32'd2, "R5 ext reload");
    rd_exp(8'h18, 32'h10, "R10 ch1 status bit 4");
    check_irq(1'b0, "R11 masked");
    wr(8'h14, 32'h10); check_irq(1'b1, "R11 enabled");
    wr(8'h18, 32'h01); check_irq(1'b1, "R10 other bit no clear");
    wr(8'h18, 32'h10); check_irq(1'b0, "R10 w1c");

    repeat (4) @(negedge pclk);
    finish_run();
  end
endmodule